// File: doc/BRIEF.md
# MATS+ Memory Self-Test Controller

This block runs the MATS+ March test on a RAM with one-bit words, without help from outside. A one-cycle start request sends it through three March elements. The first writes 0 to every word. The second visits the words in ascending order; at each word it reads, expecting 0, and then writes 1. The third visits the words in descending order; at each word it reads, expecting 1, and then writes 0. When the test finishes, the block raises a pass flag or a fail flag and holds it.

Outside a test, the RAM port simply repeats the functional address, enables and write data. While a test runs, the block takes over the port. A mux selects the self-test address, which comes from an up/down linear feedback shift register. The register has an extra zero-insertion term, so it steps through all 2^ADDR_W addresses. Each step runs forwards or backwards, matching the direction of the current March element.

The controller uses nine states: two for each of the three elements, plus an idle/start state, a fail state and a pass state. The fail state and the pass state are both terminal until the next start request.

Top module: `mbist_matsp`

## Requirements
- R1: After reset, busy_o, pass_o and fail_o are 0.
- R2: While busy_o is 0, ram_addr_o, ram_we_o, ram_re_o and ram_wdata_o equal func_addr_i, func_we_i, func_re_i and func_wdata_i in the same cycle.
- R3: A start_i that is high at a clock edge while busy_o is 0 sets busy_o from that edge. On a fault-free RAM, busy_o stays high for exactly 1 + 5·2^ADDR_W cycles.
- R4: While busy_o is 1, the functional inputs have no effect on the RAM port.
- R5: The self-test address starts at 0 and steps upward with the rule next = {a[W-2:0], a[W-1] ^ a[K-1] ^ (a[W-2:0]==0)}, where K=1 for W=4. The first two elements each visit all 2^W addresses in this order. The third element visits them in exactly the reverse order.
- R6: The first element writes 0 to every address. The second element issues, for each address, a read followed on the next cycle by a write of 1. The third element does the same but writes 0. Read data is sampled one cycle after ram_re_o, in the cycle of the paired write. After a fault-free run, every word holds 0.
- R7: When no read mismatches, busy_o falls and pass_o rises together. pass_o then holds until the next start.
- R8: On the first read mismatch, the write of that same cycle is suppressed. busy_o falls and fail_o rises at the next edge, and fail_o holds until the next start. The test detects stuck-at-0 cells, stuck-at-1 cells and address decoder faults that alias one address onto another.
- R9: start_i is ignored while busy_o is 1.
- R10: A start_i given in the pass state or the fail state clears the flag and runs a full new test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a self-test |
| func_addr_i | input | ADDR_W | Functional address |
| func_we_i | input | 1 | Functional write enable |
| func_re_i | input | 1 | Functional read enable |
| func_wdata_i | input | 1 | Functional write data |
| ram_rdata_i | input | 1 | RAM read data, valid the cycle after a read |
| ram_addr_o | output | ADDR_W | RAM address |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_wdata_o | output | 1 | RAM write data |
| busy_o | output | 1 | Self-test in progress |
| pass_o | output | 1 | Last test completed without mismatch |
| fail_o | output | 1 | Last test found a mismatch |

## Verification
On every cycle, the assertions check the following: every compare state follows a read request; the stepper reloads to 0 and holds when idle; a start request during a run never restarts the run; the terminal flags hold; and busy only falls into exactly one of pass or fail. Only the bench scenarios can show the rest. These are the exact address order forward and backward, the run length, the memory left all zero, the muting of the functional inputs, and the stop at the precise faulty address for stuck-at-0, stuck-at-1 and aliasing faults.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   typedef enum logic [3:0] {
      ST_START   = 4'd0,
      ST_M0_INIT = 4'd1,
      ST_M0_WR   = 4'd2,
      ST_M1_RD   = 4'd3,
      ST_M1_WR   = 4'd4,
      ST_M2_RD   = 4'd5,
      ST_M2_WR   = 4'd6,
      ST_ERROR   = 4'd7,
      ST_CORRECT = 4'd8
   } mbist_state_e;

   localparam int unsigned MARCH_ELEMS = 3;
   localparam int unsigned STATE_COUNT = 2 * MARCH_ELEMS + 3;

   // Second exponent K of a primitive trinomial x^W + x^K + 1; 0 = unsupported.
   function automatic int unsigned lfsr_tap(input int unsigned w);
      case (w)
         2, 3, 4, 6, 7: lfsr_tap = 1;
         5:             lfsr_tap = 2;
         9:             lfsr_tap = 4;
         10:            lfsr_tap = 3;
         11:            lfsr_tap = 2;
         default:       lfsr_tap = 0;
      endcase
   endfunction

endpackage

// File: rtl/mbist_addr_stepper.sv
module mbist_addr_stepper #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              down_i,
   output logic [ADDR_W-1:0] addr_o
);
   import mbist_pkg::*;

   localparam int unsigned TAP = lfsr_tap(ADDR_W);

   generate
      if (TAP == 0) begin : g_bad_width
         $error("mbist_addr_stepper: ADDR_W has no trinomial tap");
      end
   endgenerate

   logic [ADDR_W-1:0] q_r;
   logic [ADDR_W-1:0] q_up;
   logic [ADDR_W-1:0] q_dn;
   logic              up_zero;
   logic              dn_zero;

   always_comb begin
      up_zero = (q_r[ADDR_W-2:0] == '0);
      dn_zero = (q_r[ADDR_W-1:1] == '0);
      q_up    = {q_r[ADDR_W-2:0], q_r[ADDR_W-1] ^ q_r[TAP-1] ^ up_zero};
      q_dn    = {q_r[0] ^ q_r[TAP] ^ dn_zero, q_r[ADDR_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_r <= '0;
      else if (load_i) q_r <= '0;
      else if (step_i) q_r <= down_i ? q_dn : q_up;
   end

   assign addr_o = q_r;

   p_load_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (addr_o == '0));

   p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_i) |=> $stable(addr_o));

   p_up_down_inverse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !down_i && !load_i) ##1 (step_i && down_i && !load_i)
      |=> (addr_o == $past(addr_o, 2)));

endmodule

// File: rtl/mbist_seq.sv
module mbist_seq #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rdata_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              load_o,
   output logic              step_o,
   output logic              down_o,
   output logic              we_o,
   output logic              re_o,
   output logic              wdata_o,
   output logic              busy_o,
   output logic              pass_o,
   output logic              fail_o
);
   import mbist_pkg::*;

   localparam logic [ADDR_W-1:0] LAST_UP = {1'b1, {(ADDR_W-1){1'b0}}};
   localparam logic [ADDR_W-1:0] LAST_DN = '0;

   initial begin
      if ($bits(mbist_state_e) < $clog2(STATE_COUNT))
         $error("mbist_seq: state type too narrow");
   end

   mbist_state_e st_r, st_nx;
   logic         mismatch;
   logic         at_up_end;
   logic         at_dn_end;

   assign at_up_end = (addr_i == LAST_UP);
   assign at_dn_end = (addr_i == LAST_DN);

   always_comb begin
      st_nx    = st_r;
      load_o   = 1'b0;
      step_o   = 1'b0;
      down_o   = 1'b0;
      we_o     = 1'b0;
      re_o     = 1'b0;
      wdata_o  = 1'b0;
      mismatch = 1'b0;
      unique case (st_r)
         ST_START, ST_ERROR, ST_CORRECT: begin
            if (start_i) st_nx = ST_M0_INIT;
         end
         ST_M0_INIT: begin
            load_o = 1'b1;
            st_nx  = ST_M0_WR;
         end
         ST_M0_WR: begin
            we_o   = 1'b1;
            step_o = 1'b1;
            if (at_up_end) st_nx = ST_M1_RD;
         end
         ST_M1_RD: begin
            re_o  = 1'b1;
            st_nx = ST_M1_WR;
         end
         ST_M1_WR: begin
            mismatch = (rdata_i != 1'b0);
            wdata_o  = 1'b1;
            if (mismatch) begin
               st_nx = ST_ERROR;
            end else begin
               we_o = 1'b1;
               if (at_up_end) begin
                  st_nx = ST_M2_RD;
               end else begin
                  step_o = 1'b1;
                  st_nx  = ST_M1_RD;
               end
            end
         end
         ST_M2_RD: begin
            re_o   = 1'b1;
            down_o = 1'b1;
            st_nx  = ST_M2_WR;
         end
         ST_M2_WR: begin
            mismatch = (rdata_i != 1'b1);
            down_o   = 1'b1;
            if (mismatch) begin
               st_nx = ST_ERROR;
            end else begin
               we_o = 1'b1;
               if (at_dn_end) begin
                  st_nx = ST_CORRECT;
               end else begin
                  step_o = 1'b1;
                  st_nx  = ST_M2_RD;
               end
            end
         end
         default: st_nx = ST_START;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_r <= ST_START;
      else        st_r <= st_nx;
   end

   assign busy_o = (st_r != ST_START) && (st_r != ST_ERROR) && (st_r != ST_CORRECT);
   assign pass_o = (st_r == ST_CORRECT);
   assign fail_o = (st_r == ST_ERROR);

   p_check_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_r == ST_M1_WR || st_r == ST_M2_WR) |-> $past(re_o));

   p_pass_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_r == ST_CORRECT && !start_i) |=> (st_r == ST_CORRECT));

   p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_r == ST_ERROR && !start_i) |=> (st_r == ST_ERROR));

   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (st_r != ST_M0_INIT));

endmodule

// File: rtl/mbist_matsp.sv
module mbist_matsp #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] func_addr_i,
   input  logic              func_we_i,
   input  logic              func_re_i,
   input  logic              func_wdata_i,
   input  logic              ram_rdata_i,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic              ram_we_o,
   output logic              ram_re_o,
   output logic              ram_wdata_o,
   output logic              busy_o,
   output logic              pass_o,
   output logic              fail_o
);
   logic [ADDR_W-1:0] st_addr;
   logic              st_load;
   logic              st_step;
   logic              st_down;
   logic              bist_we;
   logic              bist_re;
   logic              bist_wdata;

   mbist_addr_stepper #(.ADDR_W(ADDR_W)) stepper_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (st_load),
      .step_i (st_step),
      .down_i (st_down),
      .addr_o (st_addr)
   );

   mbist_seq #(.ADDR_W(ADDR_W)) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .rdata_i (ram_rdata_i),
      .addr_i  (st_addr),
      .load_o  (st_load),
      .step_o  (st_step),
      .down_o  (st_down),
      .we_o    (bist_we),
      .re_o    (bist_re),
      .wdata_o (bist_wdata),
      .busy_o  (busy_o),
      .pass_o  (pass_o),
      .fail_o  (fail_o)
   );

   always_comb begin
      if (busy_o) begin
         ram_addr_o  = st_addr;
         ram_we_o    = bist_we;
         ram_re_o    = bist_re;
         ram_wdata_o = bist_wdata;
      end else begin
         ram_addr_o  = func_addr_i;
         ram_we_o    = func_we_i;
         ram_re_o    = func_re_i;
         ram_wdata_o = func_wdata_i;
      end
   end

   p_done_one_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (pass_o ^ fail_o));

   p_flags_clear_on_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (!pass_o && !fail_o));

endmodule

// File: tb/mbist_matsp_tb_top.sv
module mbist_matsp_tb_top;
   localparam int AW = 4;
   localparam int N  = 1 << AW;
   localparam int NSCN = 7;
   // fault mode (0 none, 1 stuck0, 2 stuck1, 3 alias), addr a, addr b, expect fail
   localparam int SCN [NSCN][4] = '{
      '{0, 0, 0, 0},
      '{2, 0, 0, 1},
      '{2, 8, 0, 1},
      '{1, 0, 0, 1},
      '{1, 5, 0, 1},
      '{3, 3, 12, 1},
      '{3, 12, 3, 1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] func_addr_i = '0;
   logic          func_we_i = 1'b0;
   logic          func_re_i = 1'b0;
   logic          func_wdata_i = 1'b0;
   logic          ram_rdata_i;
   logic [AW-1:0] ram_addr_o;
   logic          ram_we_o, ram_re_o, ram_wdata_o, busy_o, pass_o, fail_o;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   mbist_matsp #(.ADDR_W(AW)) dut_i (.*);

   // RAM model with fault injection
   logic [N-1:0]  mem;
   int            f_mode = 0;
   int            f_a = 0;
   int            f_b = 0;
   logic          rd_q = 1'b0;
   assign ram_rdata_i = rd_q;

   function automatic int eff(input int a);
      return (f_mode == 3 && a == f_a) ? f_b : a;
   endfunction

   always @(posedge clk) begin
      if (ram_re_o) begin
         if (f_mode == 1 && int'(ram_addr_o) == f_a)      rd_q <= 1'b0;
         else if (f_mode == 2 && int'(ram_addr_o) == f_a) rd_q <= 1'b1;
         else rd_q <= mem[eff(int'(ram_addr_o))];
      end
      if (ram_we_o) mem[eff(int'(ram_addr_o))] <= ram_wdata_o;
   end

   // Operation logs during a run
   int wn, rn;
   int wa [64];
   int wd [64];
   int ra [64];
   always @(negedge clk) begin
      if (busy_o && ram_we_o && wn < 64) begin wa[wn] = int'(ram_addr_o); wd[wn] = int'(ram_wdata_o); wn++; end
      if (busy_o && ram_re_o && rn < 64) begin ra[rn] = int'(ram_addr_o); rn++; end
   end

   int upseq [N];
   function automatic int up_next(input int a);
      logic [AW-1:0] v;
      v = AW'(a);
      return int'({v[AW-2:0], v[AW-1] ^ v[0] ^ (v[AW-2:0] == '0)});
   endfunction
   function automatic int idx_of(input int a);
      for (int i = 0; i < N; i++) if (upseq[i] == a) return i;
      return -1;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         finish_run();
      end
   end

   // Runs one test; returns the busy length. poke drives start and functional
   // writes in the middle of the run.
   task automatic run_test(input bit poke, output int len);
      wn = 0; rn = 0;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      len = 0;
      while (busy_o && len < 2000) begin
         len++;
         start_i   = poke && (len == 20 || len == 50);
         func_we_i = poke;
         func_re_i = poke;
         @(negedge clk);
      end
      start_i = 1'b0; func_we_i = 1'b0; func_re_i = 1'b0;
   endtask

   initial begin
      int len, exp_len, exp_w, p, bad;
      upseq[0] = 0;
      for (int i = 1; i < N; i++) upseq[i] = up_next(upseq[i-1]);
      mem = 16'hA5C3;

      // R1 reset state
      repeat (3) @(negedge clk);
      check(!busy_o && !pass_o && !fail_o, "R1 reset flags", {busy_o, pass_o, fail_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 functional pass-through while idle
      func_addr_i = 4'd9; func_we_i = 1'b1; func_wdata_i = 1'b1; func_re_i = 1'b0;
      #1;
      check(ram_addr_o == 4'd9 && ram_we_o && !ram_re_o && ram_wdata_o, "R2 pass-through a",
            {ram_addr_o, ram_we_o, ram_re_o, ram_wdata_o}, {4'd9, 3'b101});
      @(negedge clk);
      func_addr_i = 4'd6; func_we_i = 1'b0; func_wdata_i = 1'b0; func_re_i = 1'b1;
      #1;
      check(ram_addr_o == 4'd6 && !ram_we_o && ram_re_o && !ram_wdata_o, "R2 pass-through b",
            {ram_addr_o, ram_we_o, ram_re_o, ram_wdata_o}, {4'd6, 3'b010});
      @(negedge clk) func_re_i = 1'b0;
      check(mem[9] == 1'b1, "R2 functional write landed", mem[9], 1);

      // Scenario table walk
      for (int s = 0; s < NSCN; s++) begin
         f_mode = SCN[s][0]; f_a = SCN[s][1]; f_b = SCN[s][2];
         mem = 16'h5A3C;
         run_test(1'b0, len);
         case (f_mode)
            0: begin exp_len = 1 + 5*N; exp_w = 3*N; end
            2: begin p = idx_of(f_a); exp_len = 3 + N + 2*p; exp_w = N + p; end
            1: begin p = N - 1 - idx_of(f_a); exp_len = 3 + 3*N + 2*p; exp_w = 2*N + p; end
            default: begin
               p = (idx_of(f_a) > idx_of(f_b)) ? idx_of(f_a) : idx_of(f_b);
               exp_len = 3 + N + 2*p; exp_w = N + p;
            end
         endcase
         if (SCN[s][3] != 0) begin
            check(fail_o && !pass_o, "R8 fault detected", {pass_o, fail_o}, 1);
            check(len == exp_len, "R8 stop cycle", len, exp_len);
            check(wn == exp_w, "R8 mismatch write suppressed", wn, exp_w);
         end else begin
            check(pass_o && !fail_o, "R7 fault-free pass", {pass_o, fail_o}, 2);
            check(len == exp_len, "R3 run length", len, exp_len);
            bad = 0;
            for (int i = 0; i < N; i++) begin
               if (wa[i] != upseq[i] || wd[i] != 0) bad++;
               if (wa[N+i] != upseq[i] || wd[N+i] != 1) bad++;
               if (wa[2*N+i] != upseq[N-1-i] || wd[2*N+i] != 0) bad++;
               if (ra[i] != upseq[i] || ra[N+i] != upseq[N-1-i]) bad++;
            end
            check(bad == 0, "R5 R6 address order and data", bad, 0);
            check(rn == 2*N, "R6 read count", rn, 2*N);
            check(mem == '0, "R6 memory cleared", int'(mem), 0);
         end
      end

      // R8 / R10: fail holds, then restart on a repaired RAM passes
      repeat (10) @(negedge clk);
      check(fail_o && !busy_o, "R8 fail held", fail_o, 1);
      f_mode = 0;
      run_test(1'b0, len);
      check(pass_o && !fail_o && len == 1 + 5*N, "R10 restart after fail", len, 1 + 5*N);
      repeat (10) @(negedge clk);
      check(pass_o, "R7 pass held", pass_o, 1);

      // R4 / R9: functional activity and start pulses during a run
      mem = 16'hFFFF;
      func_addr_i = 4'd3; func_wdata_i = 1'b1;
      run_test(1'b1, len);
      check(len == 1 + 5*N, "R9 start ignored while busy", len, 1 + 5*N);
      check(wn == 3*N && rn == 2*N, "R4 functional writes blocked", wn, 3*N);
      check(mem == '0 && pass_o, "R4 memory contents", int'(mem), 0);
      @(negedge clk);
      check(!busy_o && ram_addr_o == 4'd3, "R2 pass-through after run", ram_addr_o, 3);

      finish_run();
   end
endmodule